// File: doc/BRIEF.md
# Trigger Event/Delay Counter

This block is the counting element of a trigger path. A microprocessor programs two 16-bit preload values, an event count and a delay, one byte at a time over an 8-bit write bus. A trigger clock then steps a 16-bit up-counter. On each rising trigger edge the counter either reloads one of the two preload values or increments, depending on three control inputs.

When the counter holds all ones and counting is enabled, a count-out flag is raised. The next increment wraps the counter to zero. To count K edges, software therefore preloads the two's complement of K. Each preload register collects its low byte in a staging holder. The low byte is written to the lower address. Writing the high byte, at the upper address, commits both bytes at once, so the counter never loads a half-written value.

The whole block runs on one system clock. The trigger clock and the control inputs pass through a synchronizer together, and a rising-edge detector turns the trigger clock into a one-cycle action strobe.

Top module: `trig_event_delay_counter`

## Requirements
- R1: After synchronous reset, `count_q` is 0, `count_out` is 0, and both preload values are 0, so a load straight after reset gives 0.
- R2: A bus write to address 0x41 stages the event-count low byte. A write to 0x42 commits {data, staged low byte} as the event-count preload.
- R3: A bus write to address 0x43 stages the delay low byte. A write to 0x44 commits {data, staged low byte} as the delay preload.
- R4: A low-byte write alone leaves the committed preload unchanged. A later load still gives the old value.
- R5: A bus cycle is a write only when `bus_cs_n` and `bus_wr_n` are both low. Writes to addresses outside 0x41..0x44 have no effect on either preload.
- R6: On a trigger rising edge with `cnt_en_n` low and both load inputs low, the counter increments by one. With `cnt_en_n` high it holds.
- R7: On a trigger rising edge with `load_evt` high, the counter takes the event-count preload. This takes priority over `load_dly` and over increment.
- R8: On a trigger rising edge with `load_dly` high and `load_evt` low, the counter takes the delay preload. This takes priority over increment.
- R9: `count_out` is 1 exactly when the counter is 0xFFFF and `cnt_en_n` (as synchronized) is low. An increment from 0xFFFF wraps to 0.
- R10: The counter acts once per rising trigger edge. Holding the trigger clock high, or low, causes no further change.
- R11: A preload rewritten while counting does not alter the running count. It takes effect at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 8 | Bus byte address |
| bus_data | input | 8 | Bus write data |
| trig_clk | input | 1 | Trigger clock, sampled and edge detected |
| cnt_en_n | input | 1 | Count enable, active low |
| load_evt | input | 1 | Load event-count preload on next trigger edge |
| load_dly | input | 1 | Load delay preload on next trigger edge |
| count_q | output | 16 | Counter value |
| count_out | output | 1 | Terminal-count flag |

## Verification
The embedded properties watch the counter on every cycle. They check that it moves only on a detected edge, that an enabled increment adds exactly one, that an event load takes the committed event value, and that a raised count-out followed by an increment wraps to zero. They also check that the edge strobe never lasts two cycles and that a committed preload changes only on a high-byte write. Only the directed scenarios show the byte addressing, the staging holder, the rejection of non-selected and foreign-address cycles, the load priority order, and the deferred effect of a rewrite made during counting, because each needs a whole bus and trigger sequence before the result is visible.

// File: rtl/trig_cnt_pkg.sv
package trig_cnt_pkg;

  localparam int CNT_W   = 16;
  localparam int BUS_W   = 8;
  localparam int ADDR_W  = 8;
  localparam int CTRL_W  = 3;

  localparam logic [ADDR_W-1:0] EVT_BASE = 8'h41;
  localparam logic [ADDR_W-1:0] DLY_BASE = 8'h43;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_INC    = 2'd1,
    ACT_LD_EVT = 2'd2,
    ACT_LD_DLY = 2'd3
  } cnt_act_e;

  function automatic cnt_act_e pick_action(input logic strobe, input logic en,
                                           input logic ld_evt, input logic ld_dly);
    cnt_act_e a;
    a = ACT_HOLD;
    if (strobe) begin
      if (ld_evt)      a = ACT_LD_EVT;
      else if (ld_dly) a = ACT_LD_DLY;
      else if (en)     a = ACT_INC;
    end
    return a;
  endfunction

endpackage

// File: rtl/trig_preload_reg.sv
module trig_preload_reg #(
  parameter int DATA_W = 16,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [DATA_W-1:0] value_q
);

  localparam int LANES = DATA_W / BUS_W;
  localparam logic [ADDR_W-1:0] LANES_A = ADDR_W'(LANES);
  localparam logic [ADDR_W-1:0] TOP_LANE = ADDR_W'(LANES - 1);

  logic [ADDR_W-1:0] offs;
  logic              hit;
  logic              commit;

  assign offs   = wr_addr - BASE_ADDR;
  assign hit    = wr_en && (offs < LANES_A);
  assign commit = hit && (offs == TOP_LANE);

  generate
    if (LANES > 1) begin : g_staged
      localparam int STG_W = DATA_W - BUS_W;
      logic [STG_W-1:0] stage_q;

      for (genvar i = 0; i < LANES - 1; i++) begin : g_lane
        always_ff @(posedge clk) begin
          if (rst)
            stage_q[i*BUS_W +: BUS_W] <= '0;
          else if (hit && offs == ADDR_W'(i))
            stage_q[i*BUS_W +: BUS_W] <= wr_data;
        end
      end

      always_ff @(posedge clk) begin
        if (rst)         value_q <= '0;
        else if (commit) value_q <= {wr_data, stage_q};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)         value_q <= '0;
        else if (commit) value_q <= wr_data;
      end
    end
  endgenerate

  // R4
  preload_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(value_q));

endmodule

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int STAGES = 2,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_in,
  input  logic [CW-1:0] ctrl_in,
  output logic          strobe,
  output logic [CW-1:0] ctrl_q
);

  logic [STAGES-1:0] trig_sh;
  logic              trig_prev;
  logic [CW-1:0]     ctrl_sh [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_sh   <= '0;
      trig_prev <= 1'b0;
    end else begin
      trig_sh   <= {trig_sh[STAGES-2:0], trig_in};
      trig_prev <= trig_sh[STAGES-1];
    end
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst)        ctrl_sh[s] <= '0;
        else if (s == 0) ctrl_sh[s] <= ctrl_in;
        else            ctrl_sh[s] <= ctrl_sh[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign strobe = trig_sh[STAGES-1] & ~trig_prev;
  assign ctrl_q = ctrl_sh[STAGES-1];

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

endmodule

// File: rtl/trig_counter_core.sv
module trig_counter_core
  import trig_cnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         en,
  input  logic         ld_evt,
  input  logic         ld_dly,
  input  logic [W-1:0] evt_val,
  input  logic [W-1:0] dly_val,
  output logic [W-1:0] q,
  output logic         tc
);

  localparam logic [W-1:0] ALL_ONES = '1;

  cnt_act_e act;

  assign act = pick_action(strobe, en, ld_evt, ld_dly);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      unique case (act)
        ACT_LD_EVT: q <= evt_val;
        ACT_LD_DLY: q <= dly_val;
        ACT_INC:    q <= q + 1'b1;
        default:    q <= q;
      endcase
    end
  end

  assign tc = (q == ALL_ONES) && en;

  // R10
  hold_without_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(q));

  // R6
  increment_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && en && !ld_evt && !ld_dly) |=> q == $past(q) + 1'b1);

  // R7
  load_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && ld_evt) |=> q == $past(evt_val));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tc && strobe && !ld_evt && !ld_dly) |=> q == '0);

endmodule

// File: rtl/trig_event_delay_counter.sv
module trig_event_delay_counter
  import trig_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              trig_clk,
  input  logic              cnt_en_n,
  input  logic              load_evt,
  input  logic              load_dly,
  output logic [CNT_W-1:0]  count_q,
  output logic              count_out
);

  logic              wr_en;
  logic [CNT_W-1:0]  evt_val;
  logic [CNT_W-1:0]  dly_val;
  logic              strobe;
  logic [CTRL_W-1:0] ctrl_s;

  assign wr_en = !bus_cs_n && !bus_wr_n;

  trig_preload_reg #(
    .DATA_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(EVT_BASE)
  ) u_evt_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(bus_addr),
    .wr_data(bus_data), .value_q(evt_val)
  );

  trig_preload_reg #(
    .DATA_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(DLY_BASE)
  ) u_dly_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(bus_addr),
    .wr_data(bus_data), .value_q(dly_val)
  );

  trig_edge_sync #(
    .STAGES(SYNC_STAGES), .CW(CTRL_W)
  ) u_sync (
    .clk(clk), .rst(rst), .trig_in(trig_clk),
    .ctrl_in({~cnt_en_n, load_dly, load_evt}),
    .strobe(strobe), .ctrl_q(ctrl_s)
  );

  trig_counter_core #(
    .W(CNT_W)
  ) u_core (
    .clk(clk), .rst(rst), .strobe(strobe),
    .en(ctrl_s[2]), .ld_evt(ctrl_s[0]), .ld_dly(ctrl_s[1]),
    .evt_val(evt_val), .dly_val(dly_val),
    .q(count_q), .tc(count_out)
  );

endmodule

// File: tb/test_trig_event_delay_counter.sv
module test_trig_event_delay_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs_n = 1'b1;
  logic        bus_wr_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        trig_clk = 1'b0;
  logic        cnt_en_n = 1'b1;
  logic        load_evt = 1'b0;
  logic        load_dly = 1'b0;
  logic [15:0] count_q;
  logic        count_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trig_event_delay_counter i_trig_event_delay_counter (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .trig_clk(trig_clk),
    .cnt_en_n(cnt_en_n), .load_evt(load_evt), .load_dly(load_dly),
    .count_q(count_q), .count_out(count_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_cycle(input logic cs_n, input logic wr_n, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs_n = cs_n; bus_wr_n = wr_n; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
  endtask

  task automatic set_ctrl(input logic en_n, input logic le, input logic ld);
    @(negedge clk);
    cnt_en_n = en_n; load_evt = le; load_dly = ld;
    wait_cyc(4);
  endtask

  task automatic pulse();
    @(negedge clk);
    trig_clk = 1'b1;
    wait_cyc(5);
    trig_clk = 1'b0;
    wait_cyc(5);
  endtask

  task automatic do_load(input logic evt);
    set_ctrl(1'b1, evt, ~evt);
    pulse();
    set_ctrl(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 count after reset", count_q, 16'h0000);
    check("R1 count_out after reset", {15'b0, count_out}, 16'h0000);
    do_load(1'b1);
    check("R1 event preload reset", count_q, 16'h0000);
    do_load(1'b0);
    check("R1 delay preload reset", count_q, 16'h0000);
  endtask

  task automatic t_write_regs();
    bus_cycle(1'b0, 1'b0, 8'h41, 8'h34);
    bus_cycle(1'b0, 1'b0, 8'h42, 8'h12);
    do_load(1'b1);
    check("R2 event preload", count_q, 16'h1234);
    bus_cycle(1'b0, 1'b0, 8'h43, 8'hCD);
    bus_cycle(1'b0, 1'b0, 8'h44, 8'hAB);
    do_load(1'b0);
    check("R3 delay preload", count_q, 16'hABCD);
  endtask

  task automatic t_staging();
    bus_cycle(1'b0, 1'b0, 8'h41, 8'h99);
    do_load(1'b1);
    check("R4 low byte alone not committed", count_q, 16'h1234);
    bus_cycle(1'b0, 1'b0, 8'h42, 8'h00);
    do_load(1'b1);
    check("R4 staged byte committed with high", count_q, 16'h0099);
  endtask

  task automatic t_ignored();
    bus_cycle(1'b1, 1'b0, 8'h42, 8'h77);
    bus_cycle(1'b0, 1'b1, 8'h44, 8'h66);
    bus_cycle(1'b0, 1'b0, 8'h45, 8'h55);
    bus_cycle(1'b0, 1'b0, 8'h40, 8'h44);
    do_load(1'b1);
    check("R5 event preload untouched", count_q, 16'h0099);
    do_load(1'b0);
    check("R5 delay preload untouched", count_q, 16'hABCD);
  endtask

  task automatic t_count();
    do_load(1'b1);
    set_ctrl(1'b0, 1'b0, 1'b0);
    pulse(); pulse(); pulse();
    check("R6 three increments", count_q, 16'h009C);
    set_ctrl(1'b1, 1'b0, 1'b0);
    pulse();
    check("R6 hold when disabled", count_q, 16'h009C);
  endtask

  task automatic t_priority();
    set_ctrl(1'b0, 1'b1, 1'b1);
    pulse();
    check("R7 event load wins", count_q, 16'h0099);
    set_ctrl(1'b0, 1'b0, 1'b1);
    pulse();
    check("R8 delay load over increment", count_q, 16'hABCD);
    set_ctrl(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_countout();
    bus_cycle(1'b0, 1'b0, 8'h43, 8'hFE);
    bus_cycle(1'b0, 1'b0, 8'h44, 8'hFF);
    do_load(1'b0);
    set_ctrl(1'b0, 1'b0, 1'b0);
    check("R9 no count_out at FFFE", {15'b0, count_out}, 16'h0000);
    pulse();
    check("R9 count at FFFF", count_q, 16'hFFFF);
    check("R9 count_out at FFFF enabled", {15'b0, count_out}, 16'h0001);
    set_ctrl(1'b1, 1'b0, 1'b0);
    check("R9 count_out needs enable", {15'b0, count_out}, 16'h0000);
    set_ctrl(1'b0, 1'b0, 1'b0);
    pulse();
    check("R9 wrap to zero", count_q, 16'h0000);
    check("R9 count_out low after wrap", {15'b0, count_out}, 16'h0000);
  endtask

  task automatic t_level();
    @(negedge clk);
    trig_clk = 1'b1;
    wait_cyc(20);
    check("R10 high level counts once", count_q, 16'h0001);
    trig_clk = 1'b0;
    wait_cyc(20);
    check("R10 low level no count", count_q, 16'h0001);
    set_ctrl(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_midcount();
    bus_cycle(1'b0, 1'b0, 8'h41, 8'h10);
    bus_cycle(1'b0, 1'b0, 8'h42, 8'h00);
    do_load(1'b1);
    set_ctrl(1'b0, 1'b0, 1'b0);
    pulse(); pulse();
    bus_cycle(1'b0, 1'b0, 8'h41, 8'h00);
    bus_cycle(1'b0, 1'b0, 8'h42, 8'h05);
    check("R11 running count unaffected", count_q, 16'h0012);
    pulse();
    check("R11 counting continues", count_q, 16'h0013);
    do_load(1'b1);
    check("R11 new value at next load", count_q, 16'h0500);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_write_regs();
    t_staging();
    t_ignored();
    t_count();
    t_priority();
    t_countout();
    t_level();
    t_midcount();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule